// File: doc/BRIEF.md
# Battery Fast-Charge Controller

This block sequences the charging of a nickel-based battery pack. Per-cell voltage samples arrive in millivolts, each marked by a one-cycle valid strobe. Two comparator flags report an over-temperature or out-of-range temperature condition and an over-voltage condition. A slow time tick drives the safety timers.

The controller waits for a battery. It holds off while the temperature is out of range. It then runs a fast charge until a termination criterion fires. Depending on the rate mode, it continues with a timed top-off phase and then a pulsed maintenance trickle. Removing the pack at any time returns it to waiting.

The charge-current gate is given as an active-high enable (`chg_on`) together with its open-drain equivalent (`chg_pull_low`). In top-off and trickle the enable is pulse-modulated over a frame of 2^FRAME_LOG2 clock cycles. The number of on cycles in each frame equals the post-charge current as a fraction of the fast rate. The status lamp is pulled low only during fast charge. The current state is exported with this encoding: 0 idle, 1 hold, 2 fast, 3 top-off, 4 trickle.

Top module: `fastchg_ctrl`

## Requirements
- R1: After reset the state is idle (0), `chg_on` is 0, `chg_pull_low` is 1 and `led_pull_low` is 0.
- R2: In idle, a valid sample at or above LOW_MV moves the state to fast (2) on the next edge when `hot_flag` is 0. It moves to hold (1) when `hot_flag` is 1. Hold delivers no current and moves to fast on the edge after `hot_flag` falls.
- R3: A valid sample below LOW_MV returns any state to idle on the next edge. The timer and the peak history are cleared.
- R4: In fast, PEAK_CNT accepted samples in a row that do not exceed the highest accepted sample end the fast phase. A sample above the peak restarts that count.
- R5: In fast, NDV_CNT accepted samples in a row that are more than NDV_MV below the peak end the fast phase.
- R6: `ovp_flag` or `hot_flag` during fast or top-off moves the state straight to trickle (4), skipping top-off.
- R7: The fast-phase safety limit is counted in ticks: 4×UNIT_TICKS for `mode_sel`=00 (C/2), 2×UNIT_TICKS for 01 (1C), and UNIT_TICKS for 10 or 11 (2C). The state changes on the edge after the tick that reaches the limit.
- R8: While `inhibit` is 1 in fast, `chg_on` is 0, samples are not accepted and ticks are not counted. When `inhibit` falls, charging resumes with the stored peak and timer count.
- R9: After a peak, decline or time-out end, modes 00 and 01 enter top-off (3) and modes 10 and 11 enter trickle. Top-off ends in trickle after the same tick limit as R7. Trickle is left only by removal.
- R10: Per frame of 64 cycles (FRAME_LOG2=6), `chg_on` is high for this many cycles: top-off 4 in modes 00 and 01; trickle 2 in mode 00, and 1 in mode 01 and in modes 10/11.
- R11: `led_pull_low` is 1 exactly while the state is fast, including while inhibited.
- R12: `chg_pull_low` is always the complement of `chg_on`. In idle and hold, `chg_on` is 0; in fast without inhibit, it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_vld | input | 1 | One-cycle strobe marking a new voltage sample |
| cell_mv | input | MV_W | Per-cell voltage in millivolts |
| hot_flag | input | 1 | Temperature out of range / over maximum |
| ovp_flag | input | 1 | Cell voltage over maximum |
| mode_sel | input | 2 | Rate mode: 00 C/2, 01 1C, 1x 2C |
| inhibit | input | 1 | Suspend fast charge while high |
| tick | input | 1 | One-cycle time-base pulse |
| chg_on | output | 1 | Charge current enabled |
| chg_pull_low | output | 1 | Open-drain drive of the charge gate (1 = pull low, blocks current) |
| led_pull_low | output | 1 | Open-drain drive of the status lamp |
| state_o | output | 3 | Current state code |

## Verification
A sample strobe or tick is registered on one edge. Detection, removal and hold-release act on that same edge. The peak, decline and time-out flags come from registers, so the state change they cause lands one edge later. Each table step therefore raises its pulses for one cycle, drops them, and reads the state and enable on the falling edge after the second rising edge. That point covers both latencies. The pulse ratios are counted over a full 64-cycle window, so the result does not depend on the frame phase.

// File: rtl/fastchg_pkg.sv
package fastchg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLD    = 3'd1,
        ST_FAST    = 3'd2,
        ST_TOPOFF  = 3'd3,
        ST_TRICKLE = 3'd4
    } chg_state_e;

    typedef struct packed {
        chg_state_e st;
    } ctl_regs_t;

    // multiplier of the base time-out for each rate mode
    function automatic int unsigned mode_mult(input logic [1:0] m);
        case (m)
            2'b00:   return 4;
            2'b01:   return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic mode_has_topoff(input logic [1:0] m);
        return (m[1] == 1'b0);
    endfunction

    // frame fraction = 2^-shift of the fast rate
    function automatic logic [2:0] topoff_shift(input logic [1:0] m);
        return 3'd4;
    endfunction

    function automatic logic [2:0] trickle_shift(input logic [1:0] m);
        return (m == 2'b00) ? 3'd5 : 3'd6;
    endfunction

endpackage

// File: rtl/chg_timer.sv
module chg_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && tick && (cnt_q < limit)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/peak_tracker.sv
module peak_tracker #(
    parameter int MV_W     = 12,
    parameter int NDV_MV   = 20,
    parameter int PEAK_CNT = 3,
    parameter int NDV_CNT  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            accept,
    input  logic [MV_W-1:0] mv,
    output logic            peak_hit,
    output logic            drop_hit
);

    localparam int FC_W = $clog2(PEAK_CNT + 1);
    localparam int DC_W = $clog2(NDV_CNT + 1);
    localparam logic [FC_W-1:0] FC_MAX = FC_W'(PEAK_CNT);
    localparam logic [DC_W-1:0] DC_MAX = DC_W'(NDV_CNT);

    typedef struct packed {
        logic [MV_W-1:0] peak;
        logic [FC_W-1:0] flat;
        logic [DC_W-1:0] drop;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [MV_W:0] mv_plus;
    logic          new_high;
    logic          below;

    always_comb begin
        mv_plus  = {1'b0, mv} + (MV_W+1)'(NDV_MV);
        new_high = (mv > trk_q.peak);
        below    = (mv_plus < {1'b0, trk_q.peak});
        trk_d    = trk_q;
        if (clr) begin
            trk_d = '0;
        end else if (accept) begin
            if (new_high) begin
                trk_d.peak = mv;
                trk_d.flat = '0;
            end else if (trk_q.flat < FC_MAX) begin
                trk_d.flat = trk_q.flat + 1'b1;
            end
            if (!below) begin
                trk_d.drop = '0;
            end else if (trk_q.drop < DC_MAX) begin
                trk_d.drop = trk_q.drop + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign peak_hit = (trk_q.flat >= FC_MAX);
    assign drop_hit = (trk_q.drop >= DC_MAX);

endmodule

// File: rtl/pulse_mod.sv
module pulse_mod #(
    parameter int FRAME_LOG2 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] shift,
    output logic       on
);

    logic [FRAME_LOG2-1:0] cnt_d, cnt_q;
    logic [FRAME_LOG2:0]   on_slots;

    always_comb begin
        cnt_d    = run ? (cnt_q + 1'b1) : '0;
        on_slots = (FRAME_LOG2+1)'(1) << (FRAME_LOG2 - int'(shift));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign on = run && ({1'b0, cnt_q} < on_slots);

endmodule

// File: rtl/fastchg_ctrl.sv
module fastchg_ctrl
    import fastchg_pkg::*;
#(
    parameter int MV_W       = 12,
    parameter int LOW_MV     = 2000,
    parameter int NDV_MV     = 20,
    parameter int PEAK_CNT   = 3,
    parameter int NDV_CNT    = 2,
    parameter int UNIT_TICKS = 40,
    parameter int FRAME_LOG2 = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            samp_vld,
    input  logic [MV_W-1:0] cell_mv,
    input  logic            hot_flag,
    input  logic            ovp_flag,
    input  logic [1:0]      mode_sel,
    input  logic            inhibit,
    input  logic            tick,
    output logic            chg_on,
    output logic            chg_pull_low,
    output logic            led_pull_low,
    output logic [2:0]      state_o
);

    localparam int CNT_W = $clog2(4 * UNIT_TICKS + 1);
    localparam logic [MV_W-1:0] LOW_V = MV_W'(LOW_MV);

    ctl_regs_t  cur_q, nxt_d;
    logic       absent, present;
    logic       fast_run;
    logic       tmr_clr, tmr_run, tmr_expired;
    logic       trk_clr, trk_accept, peak_hit, drop_hit;
    logic [CNT_W-1:0] tmr_limit;
    logic       pwm_run, pwm_on;
    logic [2:0] pwm_shift;

    always_comb begin
        absent   = samp_vld && (cell_mv < LOW_V);
        present  = samp_vld && !absent;
        fast_run = (cur_q.st == ST_FAST) && !inhibit;
        tmr_limit = CNT_W'(UNIT_TICKS * mode_mult(mode_sel));

        nxt_d = cur_q;
        case (cur_q.st)
            ST_IDLE: begin
                if (present) nxt_d.st = hot_flag ? ST_HOLD : ST_FAST;
            end
            ST_HOLD: begin
                if (!hot_flag) nxt_d.st = ST_FAST;
            end
            ST_FAST: begin
                if (hot_flag || ovp_flag) begin
                    nxt_d.st = ST_TRICKLE;
                end else if (!inhibit && (peak_hit || drop_hit || tmr_expired)) begin
                    nxt_d.st = mode_has_topoff(mode_sel) ? ST_TOPOFF : ST_TRICKLE;
                end
            end
            ST_TOPOFF: begin
                if (hot_flag || ovp_flag || tmr_expired) nxt_d.st = ST_TRICKLE;
            end
            ST_TRICKLE: begin
                nxt_d.st = ST_TRICKLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
        if (absent) nxt_d.st = ST_IDLE;

        tmr_clr    = (nxt_d.st != cur_q.st);
        tmr_run    = fast_run || (cur_q.st == ST_TOPOFF);
        trk_clr    = (cur_q.st != ST_FAST);
        trk_accept = fast_run && present;
        pwm_run    = (cur_q.st == ST_TOPOFF) || (cur_q.st == ST_TRICKLE);
        pwm_shift  = (cur_q.st == ST_TOPOFF) ? topoff_shift(mode_sel)
                                             : trickle_shift(mode_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.st <= ST_IDLE;
        else        cur_q    <= nxt_d;
    end

    chg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .tick    (tick),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    peak_tracker #(
        .MV_W     (MV_W),
        .NDV_MV   (NDV_MV),
        .PEAK_CNT (PEAK_CNT),
        .NDV_CNT  (NDV_CNT)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (trk_clr),
        .accept   (trk_accept),
        .mv       (cell_mv),
        .peak_hit (peak_hit),
        .drop_hit (drop_hit)
    );

    pulse_mod #(.FRAME_LOG2(FRAME_LOG2)) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pwm_run),
        .shift (pwm_shift),
        .on    (pwm_on)
    );

    always_comb begin
        chg_on       = fast_run || pwm_on;
        chg_pull_low = !chg_on;
        led_pull_low = (cur_q.st == ST_FAST);
        state_o      = cur_q.st;
    end

endmodule

// File: rtl/fastchg_chk.sv
module fastchg_chk
    import fastchg_pkg::*;
#(
    parameter int MV_W   = 12,
    parameter int LOW_MV = 2000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            samp_vld,
    input logic [MV_W-1:0] cell_mv,
    input logic            hot_flag,
    input logic            ovp_flag,
    input logic [1:0]      mode_sel,
    input logic            inhibit,
    input logic            chg_on,
    input logic            led_pull_low,
    input logic [2:0]      state_o
);

    logic gone;
    assign gone = samp_vld && (cell_mv < MV_W'(LOW_MV));

    assert_removal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gone |=> (state_o == ST_IDLE));

    assert_hold_while_hot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_HOLD) && hot_flag && !gone |=> (state_o == ST_HOLD));

    assert_safety_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_FAST) && ovp_flag && !gone |=> (state_o == ST_TRICKLE));

    assert_inhibit_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_FAST) && inhibit && !hot_flag && !ovp_flag && !gone
        |=> (state_o == ST_FAST));

    assert_no_topoff_fast_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_FAST) && mode_sel[1] |=> (state_o != ST_TOPOFF));

    assert_trickle_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_TRICKLE) && !gone |=> (state_o == ST_TRICKLE));

    assert_no_current_waiting_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_on) |-> (state_o != ST_IDLE) && (state_o != ST_HOLD));

    assert_lamp_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led_pull_low) |-> (state_o != ST_FAST));

endmodule

bind fastchg_ctrl fastchg_chk #(.MV_W(MV_W), .LOW_MV(LOW_MV)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .samp_vld     (samp_vld),
    .cell_mv      (cell_mv),
    .hot_flag     (hot_flag),
    .ovp_flag     (ovp_flag),
    .mode_sel     (mode_sel),
    .inhibit      (inhibit),
    .chg_on       (chg_on),
    .led_pull_low (led_pull_low),
    .state_o      (state_o)
);

// File: tb/sim_fastchg_ctrl.sv
`timescale 1ns/1ps
module sim_fastchg_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_vld = 1'b0;
    logic [11:0] cell_mv = 12'd0;
    logic        hot_flag = 1'b0;
    logic        ovp_flag = 1'b0;
    logic [1:0]  mode_sel = 2'b01;
    logic        inhibit = 1'b0;
    logic        tick = 1'b0;
    logic        chg_on, chg_pull_low, led_pull_low;
    logic [2:0]  state_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fastchg_ctrl #(
        .MV_W(12), .LOW_MV(2000), .NDV_MV(20), .PEAK_CNT(3),
        .NDV_CNT(2), .UNIT_TICKS(3), .FRAME_LOG2(6)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .cell_mv(cell_mv),
        .hot_flag(hot_flag), .ovp_flag(ovp_flag), .mode_sel(mode_sel),
        .inhibit(inhibit), .tick(tick), .chg_on(chg_on),
        .chg_pull_low(chg_pull_low), .led_pull_low(led_pull_low),
        .state_o(state_o)
    );

    // {samp, mv[11:0], hot, ovp, inh, tick, state[2:0], chg[1:0]}; chg 2 = not checked
    localparam int NV = 40;
    localparam logic [21:0] TBL [NV] = '{
        {1'b1,12'd1500,4'b0000,3'd0,2'd0}, // R3 low sample keeps idle
        {1'b1,12'd2100,4'b0000,3'd2,2'd1}, // R2 detect -> fast
        {1'b1,12'd2200,4'b0000,3'd2,2'd1}, // R4 peak
        {1'b1,12'd2300,4'b0000,3'd2,2'd1},
        {1'b1,12'd2500,4'b0010,3'd2,2'd0}, // R8 sample ignored while inhibited
        {1'b0,12'd2500,4'b0011,3'd2,2'd0}, // R8 tick frozen
        {1'b1,12'd2290,4'b0000,3'd2,2'd1}, // R8 resume, flat 1
        {1'b1,12'd2290,4'b0000,3'd2,2'd1}, // flat 2
        {1'b1,12'd2310,4'b0000,3'd2,2'd1}, // R4 new high restarts count
        {1'b1,12'd2305,4'b0000,3'd2,2'd1},
        {1'b1,12'd2305,4'b0000,3'd2,2'd1},
        {1'b1,12'd2300,4'b0000,3'd3,2'd2}, // R4 R9 peak end -> top-off
        {1'b0,12'd2300,4'b0001,3'd3,2'd2}, // R9 top-off timer 1
        {1'b0,12'd2300,4'b0001,3'd3,2'd2},
        {1'b0,12'd2300,4'b0001,3'd3,2'd2},
        {1'b0,12'd2300,4'b0001,3'd3,2'd2},
        {1'b0,12'd2300,4'b0001,3'd3,2'd2},
        {1'b0,12'd2300,4'b0001,3'd4,2'd2}, // R9 top-off limit -> trickle
        {1'b1,12'd1800,4'b0000,3'd0,2'd0}, // R3 removal from trickle
        {1'b1,12'd2100,4'b0000,3'd2,2'd1},
        {1'b1,12'd2400,4'b0000,3'd2,2'd1}, // R5 peak 2400
        {1'b1,12'd2370,4'b0000,3'd2,2'd1}, // R5 decline 1
        {1'b1,12'd2370,4'b0000,3'd3,2'd2}, // R5 decline 2 -> top-off
        {1'b1,12'd1900,4'b0000,3'd0,2'd0}, // R3
        {1'b1,12'd2100,4'b1000,3'd1,2'd0}, // R2 hot -> hold
        {1'b0,12'd2100,4'b1000,3'd1,2'd0}, // R2 stays in hold
        {1'b0,12'd2100,4'b0000,3'd2,2'd1}, // R2 release -> fast
        {1'b0,12'd2100,4'b0100,3'd4,2'd2}, // R6 over-voltage -> trickle
        {1'b1,12'd1500,4'b0000,3'd0,2'd0},
        {1'b1,12'd2100,4'b0000,3'd2,2'd1}, // R7 1C limit 6 ticks
        {1'b0,12'd2100,4'b0001,3'd2,2'd1},
        {1'b0,12'd2100,4'b0001,3'd2,2'd1},
        {1'b0,12'd2100,4'b0001,3'd2,2'd1},
        {1'b0,12'd2100,4'b0001,3'd2,2'd1},
        {1'b0,12'd2100,4'b0001,3'd2,2'd1},
        {1'b0,12'd2100,4'b0001,3'd3,2'd2}, // R7 sixth tick -> top-off
        {1'b1,12'd1500,4'b0000,3'd0,2'd0},
        {1'b1,12'd2100,4'b0000,3'd2,2'd1},
        {1'b0,12'd2100,4'b1000,3'd4,2'd2}, // R6 over-temperature -> trickle
        {1'b1,12'd1500,4'b0000,3'd0,2'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle of pulses, then read after the second rising edge
    task automatic step(input logic s, input logic [11:0] mv, input logic h,
                        input logic o, input logic i, input logic t);
        @(negedge clk);
        samp_vld = s; cell_mv = mv; hot_flag = h; ovp_flag = o; inhibit = i; tick = t;
        @(negedge clk);
        samp_vld = 1'b0; tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic pwm_count(output int n, output int mism);
        n = 0; mism = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (chg_on) n++;
            if (chg_pull_low == chg_on) mism++;
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        int n, mism;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 state", state_o, 0);
        check("R1 chg_on", chg_on, 0);
        check("R1 chg_pull_low", chg_pull_low, 1);
        check("R1 led", led_pull_low, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk, mode 1C
        for (int v = 0; v < NV; v++) begin
            logic [21:0] e;
            e = TBL[v];
            step(e[21], e[20:9], e[8], e[7], e[6], e[5]);
            check($sformatf("table step %0d state", v), state_o, int'(e[4:2]));
            if (e[1:0] != 2'd2)
                check($sformatf("table step %0d chg_on", v), chg_on, int'(e[1:0]));
            check($sformatf("table step %0d R12 complement", v), chg_pull_low, int'(!chg_on));
        end

        // R11 lamp in fast and inhibited fast
        step(1, 12'd2100, 0, 0, 0, 0);
        check("R11 lamp fast", led_pull_low, 1);
        step(0, 12'd2100, 0, 0, 1, 0);
        check("R11 lamp inhibited", led_pull_low, 1);
        check("R8 no current inhibited", chg_on, 0);
        step(1, 12'd2200, 0, 0, 0, 0);
        step(1, 12'd2200, 0, 0, 0, 0);
        step(1, 12'd2200, 0, 0, 0, 0);
        step(1, 12'd2200, 0, 0, 0, 0);
        check("R9 mode 01 top-off", state_o, 3);
        check("R11 lamp released", led_pull_low, 0);
        pwm_count(n, mism);
        check("R10 top-off 1C on count", n, 4);
        check("R12 complement top-off", mism, 0);
        step(0, 12'd2200, 0, 1, 0, 0);
        check("R6 top-off over-voltage", state_o, 4);
        pwm_count(n, mism);
        check("R10 trickle 1C on count", n, 1);
        step(1, 12'd1500, 0, 0, 0, 0);

        // mode 2C: peak end goes to trickle, timer freeze under inhibit
        mode_sel = 2'b10;
        step(1, 12'd2100, 0, 0, 0, 0);
        step(0, 12'd2100, 0, 0, 1, 1);
        step(0, 12'd2100, 0, 0, 1, 1);
        step(0, 12'd2100, 0, 0, 1, 1);
        step(0, 12'd2100, 0, 0, 1, 1);
        check("R8 timer frozen", state_o, 2);
        step(0, 12'd2100, 0, 0, 0, 1);
        step(0, 12'd2100, 0, 0, 0, 1);
        check("R7 2C before limit", state_o, 2);
        step(0, 12'd2100, 0, 0, 0, 1);
        check("R7 R9 2C limit -> trickle", state_o, 4);
        step(1, 12'd1500, 0, 0, 0, 0);
        step(1, 12'd2100, 0, 0, 0, 0);
        step(1, 12'd2200, 0, 0, 0, 0);
        step(1, 12'd2200, 0, 0, 0, 0);
        step(1, 12'd2200, 0, 0, 0, 0);
        step(1, 12'd2200, 0, 0, 0, 0);
        check("R4 R9 2C peak -> trickle", state_o, 4);
        pwm_count(n, mism);
        check("R10 trickle 2C on count", n, 1);
        step(1, 12'd1500, 0, 0, 0, 0);

        // mode C/2: 12-tick limit, top-off then trickle
        mode_sel = 2'b00;
        step(1, 12'd2100, 0, 0, 0, 0);
        for (int k = 0; k < 11; k++) step(0, 12'd2100, 0, 0, 0, 1);
        check("R7 C/2 eleven ticks", state_o, 2);
        step(0, 12'd2100, 0, 0, 0, 1);
        check("R7 C/2 limit -> top-off", state_o, 3);
        pwm_count(n, mism);
        check("R10 top-off C/2 on count", n, 4);
        for (int k = 0; k < 11; k++) step(0, 12'd2100, 0, 0, 0, 1);
        check("R9 top-off before limit", state_o, 3);
        step(0, 12'd2100, 0, 0, 0, 1);
        check("R9 top-off C/2 limit", state_o, 4);
        pwm_count(n, mism);
        check("R10 trickle C/2 on count", n, 2);
        check("R12 complement trickle", mism, 0);
        step(1, 12'd1999, 0, 0, 0, 0);
        check("R3 just below threshold", state_o, 0);
        step(1, 12'd2000, 0, 0, 0, 0);
        check("R2 threshold value starts", state_o, 2);

        finished = 1'b1;
        finish_run();
    end

endmodule